// File: doc/BRIEF.md
# Clock Loss Monitor

This block watches up to eight subordinate clock domains and flags any domain whose clock has stopped. It drives one probe line to all domains. The probe toggles at the start of every test period. Each domain is expected to register the probe on its own clock and return it as an echo. The echoes are asynchronous to the monitor clock, so each one passes through a two-flop synchronizer. At the last cycle of every period, the block compares each synchronized echo with the probe level of that period. A domain whose echo differs gets its sticky loss flag set.

Software reaches the block through a small register port. Through it, software sets the period length in monitor clock cycles, enables or masks each flag's contribution to the interrupt, and chooses whether reading the loss flags clears them. A flag can be cleared one at a time by writing a one to it. That write only works if the domain's echo matched at the most recent period end. The interrupt output is high while any flag is both set and enabled.

Top module: `clk_loss_monitor`

## Requirements
- R1: After reset, the loss flags, enable mask, period and clear-on-read option all read zero, and both the probe and the interrupt are low.
- R2: With a nonzero period value P, the probe toggles exactly once every P monitor clock cycles.
- R3: A period value of zero stops monitoring: the probe holds its level and no flag is set.
- R4: At a period end, each domain whose synchronized echo differs from the probe level of the ending period has its flag set, and the flag stays set after the domain's clock returns.
- R5: A domain that keeps echoing the probe through its own clock, at any rate well inside the period, never has its flag set.
- R6: Writing a one to a flag bit clears that flag when the domain's echo matched at the most recent period end.
- R7: Writing a one to a flag bit is ignored when the domain's echo mismatched at the most recent period end.
- R8: A read of the flag register returns the flags. It clears all flags in the same cycle only when the clear-on-read option (bit 0 of register 3) is one.
- R9: The interrupt is high exactly when some flag is set and its mask bit (register 1) is one.
- R10: Registers are selected by reg_sel: 0 loss flags, 1 enable mask, 2 period, 3 option. Writes to registers 1 to 3 read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_o | output | 1 | Test signal sent to every domain |
| echo_i | input | NUM_DOMAINS | Echo of the probe from each domain, asynchronous |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; needed for clear-on-read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| irq_o | output | 1 | Summary interrupt |

## Verification
The domains are modelled with eight clocks of different rates. Running all of them shows that asynchronous echoes arriving at varied phases raise no flag. Stopping chosen domains with their echo frozen shows that exactly those flags rise and stay set. With a domain still stopped, a clear is issued right after a period end whose comparison failed. Once the domain runs again, the same clear is repeated, which separates the restored case from the unrestored one. A zero period, two period lengths, and reads with and without the clear option cover the remaining modes.

// File: rtl/clm_pkg.sv
package clm_pkg;
    typedef enum logic [1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_OPTION = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/clm_sync.sv
module clm_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stable;
        } sync_t;
        sync_t s_d, s_q;

        always_comb begin
            s_d.meta   = async_i[i];
            s_d.stable = s_q.meta;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign sync_o[i] = s_q.stable;
    end
endmodule

// File: rtl/clm_period_timer.sv
module clm_period_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_cfg,
    output logic                probe_o,
    output logic                tick_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                probe;
    } tmr_t;
    tmr_t t_d, t_q;
    logic tick;

    always_comb begin
        t_d  = t_q;
        tick = 1'b0;
        if (period_cfg == '0) begin
            t_d.cnt = '0;
        end else if (t_q.cnt >= period_cfg - 1'b1) begin
            tick      = 1'b1;
            t_d.cnt   = '0;
            t_d.probe = ~t_q.probe;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign probe_o = t_q.probe;
    assign tick_o  = tick;

    // R2: probe changes only right after a period end
    a_r2_probe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(t_q.probe) |-> $past(tick));

    // R3: zero period freezes the probe
    a_r3_zero_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (period_cfg == '0) |=> $stable(t_q.probe));
endmodule

// File: rtl/clm_loss_status.sv
module clm_loss_status #(
    parameter int NUM = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           probe_i,
    input  logic [NUM-1:0] echo_sync_i,
    input  logic [NUM-1:0] w1c_i,
    input  logic           rd_clr_i,
    output logic [NUM-1:0] flags_o
);
    typedef struct packed {
        logic [NUM-1:0] flags;
        logic [NUM-1:0] ok;
    } st_t;
    st_t s_d, s_q;
    logic [NUM-1:0] miss;
    logic [NUM-1:0] clr;
    logic [NUM-1:0] set;

    always_comb begin
        miss = echo_sync_i ^ {NUM{probe_i}};
        set  = tick_i ? miss : '0;
        clr  = rd_clr_i ? '1 : (w1c_i & s_q.ok);
        s_d.flags = (s_q.flags & ~clr) | set;
        s_d.ok    = tick_i ? ~miss : s_q.ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.flags <= '0;
            s_q.ok    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_o = s_q.flags;

    // R4: flags rise only at a period end
    a_r4_set_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (|(s_q.flags & ~$past(s_q.flags))) |-> $past(tick_i));

    // R7: unrestored flags survive any write-one
    a_r7_w1c_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> (($past(s_q.flags & ~s_q.ok) & ~s_q.flags) == '0));

    // R8: clear-on-read empties the flags when no period ends
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !tick_i) |=> (s_q.flags == '0));
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
    parameter int NUM_DOMAINS = 8,
    parameter int PERIOD_W    = 16,
    parameter int DATA_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   probe_o,
    input  logic [NUM_DOMAINS-1:0] echo_i,
    input  logic [1:0]             reg_sel,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic                   irq_o
);
    import clm_pkg::*;

    typedef struct packed {
        logic [NUM_DOMAINS-1:0] mask;
        logic [PERIOD_W-1:0]    period;
        logic                   rd_clr_en;
    } cfg_t;
    cfg_t c_d, c_q;

    logic [NUM_DOMAINS-1:0] echo_sync;
    logic [NUM_DOMAINS-1:0] flags;
    logic [NUM_DOMAINS-1:0] w1c;
    logic                   rd_clr;
    logic                   tick;
    reg_sel_e               sel;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            case (sel)
                SEL_MASK:   c_d.mask      = reg_wdata[NUM_DOMAINS-1:0];
                SEL_PERIOD: c_d.period    = reg_wdata[PERIOD_W-1:0];
                SEL_OPTION: c_d.rd_clr_en = reg_wdata[0];
                default:    ;
            endcase
        end
        w1c    = (reg_wr && sel == SEL_FLAGS) ? reg_wdata[NUM_DOMAINS-1:0] : '0;
        rd_clr = reg_rd && (sel == SEL_FLAGS) && c_q.rd_clr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_FLAGS:  reg_rdata[NUM_DOMAINS-1:0] = flags;
            SEL_MASK:   reg_rdata[NUM_DOMAINS-1:0] = c_q.mask;
            SEL_PERIOD: reg_rdata[PERIOD_W-1:0]    = c_q.period;
            default:    reg_rdata[0]               = c_q.rd_clr_en;
        endcase
    end

    assign irq_o = |(flags & c_q.mask);

    clm_sync #(.WIDTH(NUM_DOMAINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (echo_i),
        .sync_o  (echo_sync)
    );

    clm_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_cfg (c_q.period),
        .probe_o    (probe_o),
        .tick_o     (tick)
    );

    clm_loss_status #(.NUM(NUM_DOMAINS)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .probe_i     (probe_o),
        .echo_sync_i (echo_sync),
        .w1c_i       (w1c),
        .rd_clr_i    (rd_clr),
        .flags_o     (flags)
    );

    // R10: option write lands one cycle later
    a_r10_option_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_OPTION) |=> (c_q.rd_clr_en == $past(reg_wdata[0])));

    initial begin
        a_r10_widths: assert (NUM_DOMAINS <= DATA_W && PERIOD_W <= DATA_W);
    end
endmodule

// File: tb/clk_loss_monitor_bench.sv
`timescale 1ns/1ps
module clk_loss_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        probe;
    wire  [7:0]  echo;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [7:0]  run = 8'hFF;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    clk_loss_monitor u_clk_loss_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_o   (probe),
        .echo_i    (echo),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq)
    );

    for (genvar g = 0; g < 8; g++) begin : g_dom
        logic dclk = 1'b0;
        logic e_q;
        initial forever #(3 + g) dclk = ~dclk;
        always @(posedge dclk or negedge rst_n) begin
            if (!rst_n)      e_q <= 1'b0;
            else if (run[g]) e_q <= probe;
        end
        assign echo[g] = e_q;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [15:0] data);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 data = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_toggle();
        logic p;
        p = probe;
        @(negedge clk);
        while (probe == p) @(negedge clk);
    endtask

    task automatic wait_periods(input int n);
        repeat (n) wait_toggle();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        chk(probe == 1'b0, "R1 probe", probe, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        for (int s = 0; s < 4; s++) begin
            reg_read(s[1:0], d);
            chk(d == 16'h0, "R1 register", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [15:0] d;
        reg_write(2'd1, 16'h00A5);
        reg_write(2'd3, 16'h0001);
        reg_read(2'd1, d); chk(d == 16'h00A5, "R10 mask", d, 16'h00A5);
        reg_read(2'd2, d); chk(d == 16'h0000, "R10 period", d, 0);
        reg_read(2'd3, d); chk(d == 16'h0001, "R10 option", d, 1);
        reg_write(2'd1, 16'h0000);
        reg_write(2'd3, 16'h0000);
    endtask

    task automatic t_zero_period();
        logic p;
        logic [15:0] d;
        p = probe;
        run[2] = 1'b0;
        repeat (60) @(negedge clk);
        chk(probe == p, "R3 probe held", probe, p);
        reg_read(2'd0, d);
        chk(d == 16'h0, "R3 no flags", d, 0);
        run[2] = 1'b1;
    endtask

    task automatic t_toggle();
        int n;
        reg_write(2'd2, 16'd10);
        wait_toggle();
        for (int k = 0; k < 2; k++) begin
            logic p;
            p = probe; n = 0;
            while (probe == p) begin @(negedge clk); n++; end
            chk(n == 10, "R2 toggle interval", n, 10);
        end
        reg_write(2'd2, 16'd20);
        wait_toggle();
        begin
            logic p;
            p = probe; n = 0;
            while (probe == p) begin @(negedge clk); n++; end
            chk(n == 20, "R2 toggle interval long", n, 20);
        end
    endtask

    task automatic t_clean();
        logic [15:0] d;
        wait_periods(6);
        reg_read(2'd0, d);
        chk(d == 16'h0, "R5 clean domains", d, 0);
    endtask

    task automatic t_loss();
        logic [15:0] d;
        run[3] = 1'b0; run[6] = 1'b0;
        wait_periods(3);
        reg_read(2'd0, d);
        chk(d == 16'h0048, "R4 stopped domains flagged", d, 16'h48);
    endtask

    task automatic t_w1c_blocked();
        logic [15:0] d;
        bit hit = 0;
        for (int k = 0; k < 4 && !hit; k++) begin
            wait_toggle();
            if (probe == echo[3]) hit = 1;
        end
        reg_write(2'd0, 16'h0008);
        reg_read(2'd0, d);
        chk(d[3] == 1'b1, "R7 write-one ignored while lost", d, 16'h48);
    endtask

    task automatic t_w1c_ok();
        logic [15:0] d;
        run[3] = 1'b1; run[6] = 1'b1;
        wait_periods(3);
        reg_read(2'd0, d);
        chk(d == 16'h0048, "R4 sticky after restore", d, 16'h48);
        wait_toggle();
        reg_write(2'd0, 16'h0048);
        reg_read(2'd0, d);
        chk(d == 16'h0, "R6 write-one clears", d, 0);
    endtask

    task automatic t_irq();
        run[1] = 1'b0;
        wait_periods(3);
        run[1] = 1'b1;
        wait_periods(3);
        @(negedge clk);
        chk(irq == 1'b0, "R9 masked off", irq, 0);
        reg_write(2'd1, 16'h0002);
        chk(irq == 1'b1, "R9 enabled", irq, 1);
        reg_write(2'd1, 16'h00FD);
        chk(irq == 1'b0, "R9 other bits only", irq, 0);
        reg_write(2'd1, 16'h0002);
    endtask

    task automatic t_read_modes();
        logic [15:0] d;
        reg_read(2'd0, d); chk(d == 16'h0002, "R8 read without option", d, 2);
        reg_read(2'd0, d); chk(d == 16'h0002, "R8 no clear without option", d, 2);
        reg_write(2'd3, 16'h0001);
        reg_read(2'd0, d); chk(d == 16'h0002, "R8 read returns flags", d, 2);
        reg_read(2'd0, d); chk(d == 16'h0000, "R8 cleared by read", d, 0);
        chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_zero_period();
        t_toggle();
        t_clean();
        t_loss();
        t_w1c_blocked();
        t_w1c_ok();
        t_irq();
        t_read_modes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule